// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose input pins and turns activity on them into interrupt status. Each pin is first brought into the local clock domain. It is then tested against a trigger condition chosen per pin: a rising edge, a falling edge, either edge, a high level or a low level. Edge events are latched until software acknowledges them. Level conditions are re-evaluated every cycle.

Software works through a small word-wide register window with a single-cycle write strobe and a combinational read. It programs which pins may raise status and which pins are hidden from the interrupt line. It reads the raw and the filtered status, and clears latched edges by writing ones. One interrupt output is raised while any visible status bit is set. Pad control, pull resistors and debounce filtering belong to neighbouring blocks.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the enable (0x20), mask (0x2C), raw status (0x24) and masked status (0x28) registers read 0, and `irq_o` is low.
- R2: The registers at 0x20 (enable), 0x2C (mask), 0x34 (sense select: 1 = level, 0 = edge), 0x38 (dual-edge) and 0x3C (polarity) are read/write. Reads of 0x30 (clear) and of any other unmapped offset return 0.
- R3: In edge mode with dual-edge 0 and polarity 0, a 0→1 transition on a pin sets its raw status bit. A 1→0 transition does not. The bit is still 0 after the second rising clock edge that follows the pin change and is set after the third.
- R4: In edge mode with dual-edge 0 and polarity 1, a 1→0 transition sets the raw bit and a 0→1 transition does not.
- R5: In edge mode with dual-edge 1, both transitions set the raw bit, whatever the polarity bit holds.
- R6: In level mode, the raw bit is 1 while the synchronised pin equals 1 (polarity 0) or equals 0 (polarity 1). A clear write does not lower it for longer than the level persists.
- R7: In edge mode, a raw bit stays set until a 1 is written to that bit of the clear register. Writing 0 to a bit leaves it set, and writing all ones clears every latched pin.
- R8: A pin whose enable bit is 0 never sets its raw status bit.
- R9: Masked status (0x28) equals raw status AND NOT mask, where a mask bit of 1 hides the pin. `irq_o` is the OR of all masked status bits.
- R10: When a qualifying edge arrives in the same cycle as a clear write to that pin, the raw bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| addr_i | input | AW | Byte offset of the register accessed |
| wr_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt, high while any unmasked status bit is set |

## Verification
The hardest condition to produce from the ports is an edge that arrives in the very cycle a clear write lands on the same pin. The bench first latches the pin and lets it fall back. It then raises the pin again and counts two clock edges of synchroniser delay, and issues the clear write so that it is captured on the third edge, the one on which the edge detector fires. A sweep then crosses all five trigger modes with several before/after pin patterns and with enable and mask patterns. The expected status is worked out bitwise from the two patterns.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  output logic             irq_o
);

  localparam logic [AW-1:0] OFS_EN    = AW'(8'h20);
  localparam logic [AW-1:0] OFS_RAW   = AW'(8'h24);
  localparam logic [AW-1:0] OFS_MSKD  = AW'(8'h28);
  localparam logic [AW-1:0] OFS_MASK  = AW'(8'h2C);
  localparam logic [AW-1:0] OFS_CLR   = AW'(8'h30);
  localparam logic [AW-1:0] OFS_SENSE = AW'(8'h34);
  localparam logic [AW-1:0] OFS_DUAL  = AW'(8'h38);
  localparam logic [AW-1:0] OFS_POL   = AW'(8'h3C);

  logic [NPINS-1:0] en_q, mask_q, sense_q, dual_q, pol_q, raw_q;
  logic [NPINS-1:0] sync1_q, sync2_q, last_q;

  logic [NPINS-1:0] rise, fall, edge_hit, level_hit, clr_vec, raw_d, masked;

  assign rise      = sync2_q & ~last_q;
  assign fall      = ~sync2_q & last_q;
  assign edge_hit  = (dual_q & (rise | fall)) | (~dual_q & ((pol_q & fall) | (~pol_q & rise)));
  assign level_hit = sync2_q ^ pol_q;
  assign clr_vec   = (wr_i && addr_i == OFS_CLR) ? wdata_i : '0;

  assign raw_d = (sense_q & en_q & level_hit)
               | (~sense_q & ((raw_q & ~clr_vec) | (en_q & edge_hit)));

  assign masked = raw_q & ~mask_q;
  assign irq_o  = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      last_q  <= '0;
      raw_q   <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
      raw_q   <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_EN:    en_q    <= wdata_i;
        OFS_MASK:  mask_q  <= wdata_i;
        OFS_SENSE: sense_q <= wdata_i;
        OFS_DUAL:  dual_q  <= wdata_i;
        OFS_POL:   pol_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFS_EN:    rdata_o = en_q;
      OFS_RAW:   rdata_o = raw_q;
      OFS_MSKD:  rdata_o = masked;
      OFS_MASK:  rdata_o = mask_q;
      OFS_SENSE: rdata_o = sense_q;
      OFS_DUAL:  rdata_o = dual_q;
      OFS_POL:   rdata_o = pol_q;
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr_i,
  input logic             wr_i,
  input logic [NPINS-1:0] wdata_i,
  input logic             irq_o,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] sense_q,
  input logic [NPINS-1:0] raw_q
);

  localparam logic [AW-1:0] OFS_CLR = AW'(8'h30);

  logic [NPINS-1:0] clr_seen;
  assign clr_seen = (wr_i && addr_i == OFS_CLR) ? wdata_i : '0;

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~$past(raw_q) & ~$past(en_q)) == '0);

  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_q & ~sense_q & ~clr_seen) & ~raw_q) == '0);

  assert_level_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sense_q & ~en_q) & raw_q) == '0);

  assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == '0) |-> !irq_o);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .irq_o(irq_o), .en_q(en_q), .mask_q(mask_q), .sense_q(sense_q), .raw_q(raw_q)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_irq_detect dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pa [4];
    logic [31:0] pb [4];
    pa[0] = 32'h0000_0000; pb[0] = 32'hFFFF_FFFF;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0000;
    pa[2] = 32'h0F0F_0F0F; pb[2] = 32'h00FF_00FF;
    pa[3] = 32'hA5A5_A5A5; pb[3] = 32'h5A5A_3C3C;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h20, v); chk("R1 enable", v, 0);
    rd(8'h2C, v); chk("R1 mask", v, 0);
    rd(8'h24, v); chk("R1 raw", v, 0);
    rd(8'h28, v); chk("R1 masked", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R2 register readback
    wr(8'h20, 32'h1234_5678); rd(8'h20, v); chk("R2 enable", v, 32'h1234_5678);
    wr(8'h2C, 32'h9ABC_DEF0); rd(8'h2C, v); chk("R2 mask", v, 32'h9ABC_DEF0);
    wr(8'h34, 32'hCAFE_0001); rd(8'h34, v); chk("R2 sense", v, 32'hCAFE_0001);
    wr(8'h38, 32'h0BAD_F00D); rd(8'h38, v); chk("R2 dual", v, 32'h0BAD_F00D);
    wr(8'h3C, 32'h8000_0003); rd(8'h3C, v); chk("R2 polarity", v, 32'h8000_0003);
    rd(8'h30, v); chk("R2 clear reads zero", v, 0);
    rd(8'h00, v); chk("R2 unmapped reads zero", v, 0);

    // Sweep: 5 modes x 4 pattern pairs (R3 R4 R5 R6 R7 R8 R9)
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a, b, en, mk, exp, clr, after;
        a = pa[k]; b = pb[k];
        en = 32'hFFFF_FFFF >> (k * 8);
        mk = 32'h1234_5678 ^ (32'h1111_1111 * k);
        clr = 32'h0000_FFFF;
        wr(8'h20, 0);
        pin_i = a;
        idle(4);
        wr(8'h34, (m >= 3) ? 32'hFFFF_FFFF : 32'h0);
        wr(8'h38, (m == 2) ? 32'hFFFF_FFFF : 32'h0);
        wr(8'h3C, (m == 1 || m == 2 || m == 4) ? 32'hFFFF_FFFF : 32'h0);
        wr(8'h20, en);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h2C, mk);
        pin_i = b;
        idle(4);
        case (m)
          0: exp = ~a & b;
          1: exp = a & ~b;
          2: exp = a ^ b;
          3: exp = b;
          default: exp = ~b;
        endcase
        exp = exp & en;
        rd(8'h24, v);
        chk($sformatf("R3 R4 R5 R6 R8 raw mode %0d pair %0d", m, k), v, exp);
        rd(8'h28, v);
        chk($sformatf("R9 masked mode %0d pair %0d", m, k), v, exp & ~mk);
        chk($sformatf("R9 irq mode %0d pair %0d", m, k), {31'd0, irq_o}, {31'd0, |(exp & ~mk)});
        wr(8'h30, clr);
        idle(1);
        after = (m >= 3) ? exp : (exp & ~clr);
        rd(8'h24, v);
        chk($sformatf("R6 R7 after clear mode %0d pair %0d", m, k), v, after);
      end
    end

    // R7 clear all
    wr(8'h34, 0); wr(8'h38, 0); wr(8'h3C, 0); wr(8'h20, 32'hFFFF_FFFF); wr(8'h2C, 0);
    pin_i = 0; idle(4); wr(8'h30, 32'hFFFF_FFFF);
    pin_i = 32'hFFFF_FFFF; idle(4);
    rd(8'h24, v); chk("R7 all latched", v, 32'hFFFF_FFFF);
    wr(8'h30, 32'h0); rd(8'h24, v); chk("R7 zero write no effect", v, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h24, v); chk("R7 all ones clears", v, 0);
    chk("R9 irq low after clear", {31'd0, irq_o}, 0);

    // R3 latency
    pin_i = 0; idle(4); wr(8'h30, 32'hFFFF_FFFF); wr(8'h20, 32'h0000_0021);
    pin_i[0] = 1'b1;
    idle(2);
    rd(8'h24, v); chk("R3 not set after two edges", v & 1, 0);
    idle(1);
    rd(8'h24, v); chk("R3 set after third edge", v & 1, 1);

    // R10 edge coincident with clear
    pin_i[5] = 1'b1; idle(4);
    rd(8'h24, v); chk("R10 first edge latched", (v >> 5) & 1, 1);
    pin_i[5] = 1'b0; idle(4);
    rd(8'h24, v); chk("R3 falling ignored in rising mode", (v >> 5) & 1, 1);
    pin_i[5] = 1'b1;
    idle(2);
    wr(8'h30, 32'h0000_0020);
    rd(8'h24, v); chk("R10 edge wins over clear", (v >> 5) & 1, 1);
    wr(8'h30, 32'h0000_0020);
    rd(8'h24, v); chk("R10 plain clear", (v >> 5) & 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule